// File: doc/BRIEF.md
# Host Adapter Command Port Controller

This block is the host-facing register front end of an intelligent bus adapter. Software sees three byte registers. The first reads as status and writes as control. The second is a shared command/data port. The third is a read-only interrupt flag register. The host writes an opcode into the data port, followed by the parameter bytes that opcode expects. It then reads back the reply bytes the adapter produces through the same port.

A built-in opcode table gives, for each supported command, how many parameter bytes to collect and how many reply bytes to return. For the setup query, the reply length comes from its first parameter byte. The status flags show when each step may proceed: the host waits while the inbound byte is still unconsumed, and reads only while a reply byte is waiting. When a command finishes, the block raises a completion interrupt, which software clears through the control register. A control bit also gives a soft reset of the board logic.

Replies from the identification, configuration and device-scan commands carry fixed values. The only parameter the block keeps is the mailbox count from mailbox initialisation, which the setup query reports back.

Top module: `hacmd_port`

## Requirements
- R1: Register selection uses `addr`. Address 0 reads status and writes control, address 1 is the command/data port, address 2 reads the interrupt register, and address 3 reads 0x00. After reset, status reads 0x10 and the interrupt register reads 0x00.
- R2: The status bits are: bit 0 invalid command, bit 2 inbound byte full, bit 3 outbound byte full, bit 4 idle. All other status bits read 0.
- R3: Parameter byte counts per opcode: 0x00 takes 0, 0x01 takes 4, 0x05 takes 1, 0x06 takes 4, 0x07/0x08/0x09 take 1 each, 0x0D takes 1, 0x1F takes 1, and 0x04/0x0A/0x0B take 0. A command completes only after its last parameter is consumed.
- R4: Opcode 0x04 replies 0x41, 0x41, 0x30, 0x31. Opcode 0x0B replies 0x01, 0x04, 0x07. Opcode 0x0A replies 8 bytes, where byte i equals 1<<i.
- R5: Opcode 0x1F replies with one byte equal to its parameter byte.
- R6: Opcode 0x0D with parameter N replies with exactly N bytes. Byte index 4 is the count byte (first parameter) of the latest 0x01 command, and every other byte is 0x00. When N=0, the command completes without a reply.
- R7: An opcode outside the R3 table sets status bit 0, consumes no parameters, leaves the block idle, and raises completion at once. The next valid opcode clears status bit 0.
- R8: A data-port write while status bit 2 is set is ignored.
- R9: Reading the data port while status bit 3 is set consumes the byte. If more reply bytes remain, the next one is presented at once. After the last byte, status bit 3 is 0.
- R10: The idle bit reads 0 from opcode acceptance until the command completes. On completion, interrupt bit 2 is set. Interrupt bit 7 reads 1 whenever any of bits 0..6 is set, and `irqOut` equals interrupt bit 7.
- R11: A control write with bit 5 set clears the interrupt register.
- R12: A control write with bit 6 set aborts any command, returns the block to idle, and clears the invalid, inbound-full and outbound-full flags and the interrupt register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (data-port reads consume a reply byte) |
| rdData | output | 8 | Read data for the selected register |
| irqOut | output | 1 | Interrupt request, equal to interrupt bit 7 |

## Verification
Commands are issued in three shapes: parameters only, reply only, and parameters followed by a reply. This separates the counters for parameter intake and reply length. The echo and setup commands show whether a reply is built from the parameters just received or from state kept from an earlier command. An N=0 setup query and a no-op check that the completion path is correct when there are no bytes to move. Back-to-back data writes, an invalid opcode, and a soft reset in the middle of a reply cover the protection and recovery paths.

// File: rtl/hacmd_pkg.sv
package hacmd_pkg;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_INTR = 2'd2;

  localparam int CTRL_INTCLR_BIT = 5;
  localparam int CTRL_SOFTRST_BIT = 6;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_MBOX  = 8'h01;
  localparam logic [7:0] OP_IDENT = 8'h04;
  localparam logic [7:0] OP_MBIE  = 8'h05;
  localparam logic [7:0] OP_SELTO = 8'h06;
  localparam logic [7:0] OP_BUSON = 8'h07;
  localparam logic [7:0] OP_BUSOF = 8'h08;
  localparam logic [7:0] OP_SPEED = 8'h09;
  localparam logic [7:0] OP_DEVS  = 8'h0A;
  localparam logic [7:0] OP_CONF  = 8'h0B;
  localparam logic [7:0] OP_SETUP = 8'h0D;
  localparam logic [7:0] OP_ECHO  = 8'h1F;

  localparam logic [7:0] IDENT_B0 = 8'h41;
  localparam logic [7:0] IDENT_B1 = 8'h41;
  localparam logic [7:0] IDENT_B2 = 8'h30;
  localparam logic [7:0] IDENT_B3 = 8'h31;
  localparam logic [7:0] CONF_B0  = 8'h01;
  localparam logic [7:0] CONF_B1  = 8'h04;
  localparam logic [7:0] CONF_B2  = 8'h07;
  localparam logic [7:0] SETUP_MBOX_IDX = 8'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_PARAM, ST_PREP, ST_REPLY} cmdState_e;

  typedef struct packed {
    logic       valid;
    logic [2:0] nParam;
    logic [3:0] nReply;
    logic       lenFromParam;
  } opInfo_t;

  typedef struct packed {
    logic takeIn;
    logic latchOp;
    logic storeParam;
    logic loadReply;
    logic dropOut;
    logic setInv;
    logic clrInv;
    logic setDone;
  } strobe_t;

  function automatic opInfo_t decodeOp(input logic [7:0] op);
    opInfo_t r;
    r = '{valid: 1'b1, nParam: 3'd0, nReply: 4'd0, lenFromParam: 1'b0};
    case (op)
      OP_NOP:                      ;
      OP_MBOX, OP_SELTO:           r.nParam = 3'd4;
      OP_MBIE, OP_BUSON,
      OP_BUSOF, OP_SPEED:          r.nParam = 3'd1;
      OP_IDENT:                    r.nReply = 4'd4;
      OP_CONF:                     r.nReply = 4'd3;
      OP_DEVS:                     r.nReply = 4'd8;
      OP_ECHO: begin r.nParam = 3'd1; r.nReply = 4'd1; end
      OP_SETUP: begin r.nParam = 3'd1; r.lenFromParam = 1'b1; end
      default:                     r.valid = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hacmd_dp.sv
module hacmd_dp
  import hacmd_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int IDX_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       dataWrite,
  input  logic       intClr,
  input  logic [7:0] wrData,
  input  strobe_t    strb,
  output logic       inFull,
  output logic [7:0] inByte,
  output logic       outFull,
  output logic [7:0] outByte,
  output logic       invErr,
  output logic       intDone
);

  localparam int PIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [7:0]        opReg;
  logic [7:0]        params [SLOTS];
  logic [PIDX_W-1:0] paramIdx;
  logic [IDX_W-1:0]  replyIdx;
  logic [7:0]        mboxCount;
  logic [7:0]        replyByte;

  // inbound byte register
  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      inFull <= 1'b0;
      inByte <= 8'h00;
    end else if (dataWrite && !inFull) begin
      inFull <= 1'b1;
      inByte <= wrData;
    end else if (strb.takeIn) begin
      inFull <= 1'b0;
    end
  end

  // opcode, parameter slots and kept mailbox count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg     <= OP_NOP;
      paramIdx  <= '0;
      mboxCount <= 8'h00;
    end else if (strb.latchOp) begin
      opReg    <= inByte;
      paramIdx <= '0;
    end else if (strb.storeParam) begin
      paramIdx <= paramIdx + 1'b1;
      if (opReg == OP_MBOX && paramIdx == '0) mboxCount <= inByte;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) params[g] <= 8'h00;
      else if (strb.storeParam && paramIdx == PIDX_W'(g)) params[g] <= inByte;
    end
  end

  // reply byte source
  always_comb begin
    replyByte = 8'h00;
    case (opReg)
      OP_ECHO:  replyByte = params[0];
      OP_IDENT: case (replyIdx[1:0])
                  2'd0: replyByte = IDENT_B0;
                  2'd1: replyByte = IDENT_B1;
                  2'd2: replyByte = IDENT_B2;
                  default: replyByte = IDENT_B3;
                endcase
      OP_CONF:  case (replyIdx[1:0])
                  2'd0: replyByte = CONF_B0;
                  2'd1: replyByte = CONF_B1;
                  default: replyByte = CONF_B2;
                endcase
      OP_DEVS:  replyByte = 8'h01 << replyIdx[2:0];
      OP_SETUP: replyByte = (replyIdx == IDX_W'(SETUP_MBOX_IDX)) ? mboxCount : 8'h00;
      default:  replyByte = 8'h00;
    endcase
  end

  // outbound byte register
  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      outFull  <= 1'b0;
      outByte  <= 8'h00;
      replyIdx <= '0;
    end else begin
      if (strb.latchOp) replyIdx <= '0;
      if (strb.loadReply) begin
        outFull  <= 1'b1;
        outByte  <= replyByte;
        replyIdx <= replyIdx + 1'b1;
      end else if (strb.dropOut) begin
        outFull <= 1'b0;
      end
    end
  end

  // flags
  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      invErr  <= 1'b0;
      intDone <= 1'b0;
    end else begin
      if (strb.setInv) invErr <= 1'b1;
      else if (strb.clrInv) invErr <= 1'b0;
      if (strb.setDone) intDone <= 1'b1;
      else if (intClr) intDone <= 1'b0;
    end
  end

  assert_ignore_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inFull && dataWrite && !strb.takeIn && !softRst) |=> (inFull && inByte == $past(inByte)));

  assert_int_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (intClr && !strb.setDone && !softRst) |=> !intDone);

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!inFull && !outFull && !invErr && !intDone));

endmodule

// File: rtl/hacmd_ctrl.sv
module hacmd_ctrl
  import hacmd_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       hostRead,
  input  logic       inFull,
  input  logic [7:0] inByte,
  input  logic       outFull,
  output strobe_t    strb,
  output logic       idle
);

  cmdState_e        state, stateNx;
  logic [2:0]       paramLeft, paramLeftNx;
  logic [LEN_W-1:0] replyLeft, replyLeftNx;
  opInfo_t          info, infoNx, decoded;

  always_comb decoded = decodeOp(inByte);

  always_comb begin
    strb        = '0;
    stateNx     = state;
    paramLeftNx = paramLeft;
    replyLeftNx = replyLeft;
    infoNx      = info;
    case (state)
      ST_IDLE: if (inFull) begin
        strb.takeIn = 1'b1;
        if (!decoded.valid) begin
          strb.setInv  = 1'b1;
          strb.setDone = 1'b1;
        end else begin
          strb.latchOp = 1'b1;
          strb.clrInv  = 1'b1;
          infoNx       = decoded;
          if (decoded.nParam != 3'd0) begin
            paramLeftNx = decoded.nParam;
            stateNx     = ST_PARAM;
          end else if (decoded.nReply != 4'd0) begin
            replyLeftNx = LEN_W'(decoded.nReply);
            stateNx     = ST_PREP;
          end else begin
            strb.setDone = 1'b1;
          end
        end
      end
      ST_PARAM: if (inFull) begin
        strb.takeIn     = 1'b1;
        strb.storeParam = 1'b1;
        paramLeftNx     = paramLeft - 3'd1;
        if (paramLeft == 3'd1) begin
          replyLeftNx = info.lenFromParam ? LEN_W'(inByte) : LEN_W'(info.nReply);
          stateNx     = ST_PREP;
        end
      end
      ST_PREP: begin
        if (replyLeft == '0) begin
          strb.setDone = 1'b1;
          stateNx      = ST_IDLE;
        end else begin
          strb.loadReply = 1'b1;
          replyLeftNx    = replyLeft - 1'b1;
          stateNx        = ST_REPLY;
        end
      end
      ST_REPLY: begin
        strb.takeIn = inFull;
        if (hostRead && outFull) begin
          if (replyLeft != '0) begin
            strb.loadReply = 1'b1;
            replyLeftNx    = replyLeft - 1'b1;
          end else begin
            strb.dropOut = 1'b1;
            strb.setDone = 1'b1;
            stateNx      = ST_IDLE;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
    if (softRst) strb = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      state     <= ST_IDLE;
      paramLeft <= 3'd0;
      replyLeft <= '0;
      info      <= '0;
    end else begin
      state     <= stateNx;
      paramLeft <= paramLeftNx;
      replyLeft <= replyLeftNx;
      info      <= infoNx;
    end
  end

  assign idle = (state == ST_IDLE);

  assert_reply_has_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPLY) |-> outFull);

  assert_param_no_out_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARAM) |-> !outFull);

  assert_done_goes_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setDone && !softRst) |=> idle);

endmodule

// File: rtl/hacmd_port.sv
module hacmd_port
  import hacmd_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LEN_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData,
  output logic       irqOut
);

  strobe_t    strb;
  logic       inFull, outFull, invErr, intDone, idle;
  logic [7:0] inByte, outByte, statusReg, intrReg;
  logic       ctrlWrite, dataWrite, softRst, intClr, hostRead;

  assign ctrlWrite = wrEn && addr == REG_CTRL;
  assign dataWrite = wrEn && addr == REG_DATA;
  assign softRst   = ctrlWrite && wrData[CTRL_SOFTRST_BIT];
  assign intClr    = ctrlWrite && wrData[CTRL_INTCLR_BIT];
  assign hostRead  = rdEn && addr == REG_DATA;

  hacmd_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .hostRead(hostRead),
    .inFull(inFull), .inByte(inByte), .outFull(outFull),
    .strb(strb), .idle(idle)
  );

  hacmd_dp #(.SLOTS(SLOTS), .IDX_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .softRst(softRst), .dataWrite(dataWrite),
    .intClr(intClr), .wrData(wrData), .strb(strb),
    .inFull(inFull), .inByte(inByte), .outFull(outFull), .outByte(outByte),
    .invErr(invErr), .intDone(intDone)
  );

  assign statusReg = {3'b000, idle, outFull, inFull, 1'b0, invErr};
  assign intrReg   = {intDone, 4'b0000, intDone, 2'b00};
  assign irqOut    = intrReg[7];

  always_comb begin
    case (addr)
      REG_CTRL: rdData = statusReg;
      REG_DATA: rdData = outByte;
      REG_INTR: rdData = intrReg;
      default:  rdData = 8'h00;
    endcase
  end

endmodule

// File: tb/hacmd_port_test.sv
module hacmd_port_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]      op;
    logic [3:0]      np;
    logic [0:3][7:0] prm;
    logic [3:0]      nr;
    logic [0:7][7:0] rep;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'h1F, 4'd1, 32'hA5000000, 4'd1, 64'hA500000000000000},
    '{8'h04, 4'd0, 32'h00000000, 4'd4, 64'h4141303100000000},
    '{8'h0B, 4'd0, 32'h00000000, 4'd3, 64'h0104070000000000},
    '{8'h0A, 4'd0, 32'h00000000, 4'd8, 64'h0102040810204080},
    '{8'h01, 4'd4, 32'h05123456, 4'd0, 64'h0},
    '{8'h0D, 4'd1, 32'h06000000, 4'd6, 64'h0000000005000000},
    '{8'h00, 4'd0, 32'h00000000, 4'd0, 64'h0},
    '{8'h07, 4'd1, 32'h0B000000, 4'd0, 64'h0},
    '{8'h06, 4'd4, 32'h01000102, 4'd0, 64'h0},
    '{8'h09, 4'd1, 32'h80000000, 4'd0, 64'h0},
    '{8'h0D, 4'd1, 32'h00000000, 4'd0, 64'h0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       irqOut;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  hacmd_port uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitStatus(input int bitPos, input logic val);
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      busRead(2'd0, s);
      if (s[bitPos] == val) return;
    end
  endtask

  task automatic sendByte(input logic [7:0] d);
    busWrite(2'd1, d);
    waitStatus(2, 1'b0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 R2: reset state
    busRead(2'd0, v); check("R1 reset status", v, 8'h10);
    busRead(2'd2, v); check("R1 reset intr", v, 8'h00);
    busRead(2'd3, v); check("R1 unused addr", v, 8'h00);
    check("R10 reset irq", {7'd0, irqOut}, 8'h00);

    // table walk: R3 R4 R5 R6 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      sendByte(VECS[i].op);
      for (int p = 0; p < int'(VECS[i].np); p++) begin
        if (p == 0) begin
          busRead(2'd2, v); check("R3 no completion before params", v, 8'h00);
        end
        sendByte(VECS[i].prm[p]);
      end
      for (int r = 0; r < int'(VECS[i].nr); r++) begin
        waitStatus(3, 1'b1);
        busRead(2'd0, v); check("R10 busy with reply pending", v, 8'h08);
        busRead(2'd1, v); check("R4 R5 R6 R9 reply byte", v, VECS[i].rep[r]);
      end
      waitStatus(4, 1'b1);
      busRead(2'd0, v); check("R2 R9 status after command", v, 8'h10);
      busRead(2'd2, v); check("R10 completion interrupt", v, 8'h84);
      check("R10 irq pin", {7'd0, irqOut}, 8'h01);
      busWrite(2'd0, 8'h20);
      busRead(2'd2, v); check("R11 interrupt cleared", v, 8'h00);
      check("R11 irq low", {7'd0, irqOut}, 8'h00);
    end

    // R7: invalid opcode
    busWrite(2'd1, 8'h02);
    waitStatus(2, 1'b0);
    busRead(2'd0, v); check("R7 invalid flag idle", v, 8'h11);
    busRead(2'd2, v); check("R7 immediate completion", v, 8'h84);
    busWrite(2'd0, 8'h20);
    sendByte(8'h07);
    busRead(2'd0, v); check("R7 cleared by valid opcode", v, 8'h00);
    sendByte(8'h03);
    busRead(2'd0, v); check("R3 R7 param done", v, 8'h10);
    busWrite(2'd0, 8'h20);

    // R8: second write while inbound full is dropped
    @(negedge clk);
    addr = 2'd1; wrData = 8'h1F; wrEn = 1'b1;
    @(negedge clk);
    wrData = 8'h11;
    @(negedge clk);
    wrEn = 1'b0;
    busRead(2'd0, v); check("R8 waiting for param", v, 8'h00);
    sendByte(8'h22);
    waitStatus(3, 1'b1);
    busRead(2'd1, v); check("R8 echo ignores dropped write", v, 8'h22);
    waitStatus(4, 1'b1);
    busWrite(2'd0, 8'h20);

    // R12: soft reset during a reply
    sendByte(8'h04);
    waitStatus(3, 1'b1);
    busRead(2'd1, v); check("R4 first ident byte", v, 8'h41);
    busWrite(2'd0, 8'h40);
    busRead(2'd0, v); check("R12 status after soft reset", v, 8'h10);
    busRead(2'd2, v); check("R12 intr after soft reset", v, 8'h00);
    sendByte(8'h1F);
    sendByte(8'h5A);
    waitStatus(3, 1'b1);
    busRead(2'd1, v); check("R12 R5 works after soft reset", v, 8'h5A);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule